// File: doc/BRIEF.md
# Nested Four-Source Interrupt Arbiter

This block sits between four interrupt sources and a CPU. Each source line is watched for a rising edge, which leaves a pending flag set until that source is granted. Two orderings are kept apart. A fixed hardware order decides which source wins when several are eligible at once: source 0 (A) first, then 1, 2 and 3. Software sets the order in which an interrupt may cut into a service routine, by writing one mask word for each level. A set bit in the mask of the level in service blocks the matching source.

When an eligible request exists and the CPU's interrupt-enable input is high, the controller raises `intr_o`. The CPU answers with `inta_i`. The controller then captures the winning source, clears its pending flag and returns a vector address. It also pushes that level's mask onto a four-entry stack and pulses `ie_clr_o` so the CPU turns interrupts off before the routine runs. An end-of-service pulse pops the stack, which restores the mask of the interrupted level. When the stack is empty, no source is masked.

The control sequencer has three states. `ST_IDLE` moves to `ST_RAISE` when an eligible request exists and enable is high. `ST_RAISE` drives `intr_o`. It moves to `ST_VECTOR` on acknowledge, or back to `ST_IDLE` if enable drops or nothing stays eligible. `ST_VECTOR` presents the vector and the enable-clear strobe for one cycle and then always returns to `ST_IDLE`.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset `intr_o`, `vec_valid_o` and `ie_clr_o` are low, no request is pending and the mask stack is empty.
- R2: Bit i of `req_i` belongs to source i (A is bit 0). A request is latched only on a low-to-high change, so a line held high gives exactly one grant, and the pending flag clears when that source is granted.
- R3: Among eligible pending requests the lowest source index is granted at acknowledge.
- R4: `intr_o` rises only while `cpu_ie_i` is high. If enable falls while `intr_o` is high and no acknowledge is given, `intr_o` is low from the next cycle.
- R5: In the cycle after `inta_i` is sampled high with `intr_o` high, `vec_valid_o` is high for exactly one cycle and `vec_o` equals VEC_BASE + 4 × source index (default base 0x40: A=0x40, B=0x44, C=0x48, D=0x4C).
- R6: `ie_clr_o` pulses high in exactly the cycle in which `vec_valid_o` is high.
- R7: `mask_we_i` writes `mask_data_i` into the mask word of level `mask_lvl_i`. Bit i set blocks source i while that level is on top of the stack. The word is copied at grant time, so a later write does not change a level that is already in service.
- R8: Each grant pushes the granted level's mask onto the stack, and that mask becomes the active one. With the stack empty the active mask is all zeros.
- R9: `eos_i` pops the stack and restores the previous level's mask. `eos_i` with an empty stack has no effect.
- R10: With all four stack entries in use, no request is eligible until an end-of-service frees an entry.
- R11: A masked request stays pending and is granted once the mask that blocks it is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Request lines, bit 0 = source A |
| cpu_ie_i | input | 1 | CPU interrupt-enable state |
| inta_i | input | 1 | Acknowledge from the CPU |
| eos_i | input | 1 | End-of-service pulse, pops one level |
| mask_we_i | input | 1 | Mask word write strobe |
| mask_lvl_i | input | IDX_W | Level whose mask word is written |
| mask_data_i | input | N_SRC | Mask word data, bit i blocks source i |
| intr_o | output | 1 | Interrupt request to the CPU |
| vec_valid_o | output | 1 | Vector address valid (one cycle) |
| vec_o | output | VEC_W | Vector address |
| ie_clr_o | output | 1 | Strobe telling the CPU to clear its enable |

## Verification
The masks are loaded so that a shorter service time gives a higher processing rank: A blocks A, B and D; B blocks only itself; C blocks everything; D blocks B and D. With these masks the bench fires two sources together and then all four together. The grant order then shows the fixed hardware order and the mask-controlled nesting as separate effects: a source that loses at the same instant may still preempt the winner's routine. Further tests cover a held request line, enable being dropped while `intr_o` is high, a mask rewrite while its level is in service, four-deep nesting with all-zero masks, and an end-of-service with an empty stack. These show edge latching, the enable gating, the snapshot of the mask at grant time, the guard when the stack is full, and the fact that the stack cannot underflow.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAISE  = 2'd1,
        ST_VECTOR = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int N_SRC = 4,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             clr_vld_i,
    input  logic [IDX_W-1:0] clr_idx_i,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] rise;

    assign rise   = req_i & ~prev_q;
    assign pend_o = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= req_i;
    end

    // One flag per source: a new edge wins over a clear in the same cycle
    for (genvar s = 0; s < N_SRC; s++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[s] <= 1'b0;
            end else if (rise[s]) begin
                pend_q[s] <= 1'b1;
            end else if (clr_vld_i && (clr_idx_i == IDX_W'(s))) begin
                pend_q[s] <= 1'b0;
            end
        end
    end

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld_i && !rise[clr_idx_i]) |=> !pend_q[$past(clr_idx_i)]); // R2
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_SRC = 4,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] elig_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Lowest index wins: scan from the top so the last hit is the smallest
    always_comb begin
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |elig_i;
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack #(
    parameter int N_SRC = 4,
    parameter int DEPTH = 4,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_lvl_i,
    input  logic [N_SRC-1:0] wr_data_i,
    input  logic             push_i,
    input  logic [IDX_W-1:0] push_lvl_i,
    input  logic             pop_i,
    output logic [N_SRC-1:0] active_o,
    output logic             full_o
);
    localparam int DCW = $clog2(DEPTH + 1);
    localparam int SW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [N_SRC-1:0] mask_q [N_SRC];
    logic [N_SRC-1:0] stk_q  [DEPTH];
    logic [DCW-1:0]   depth_q;
    logic             push_ok;
    logic             pop_ok;
    logic [SW-1:0]    top_idx;

    assign full_o  = (depth_q == DCW'(DEPTH));
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !push_i && (depth_q != '0);
    assign top_idx = SW'(depth_q - DCW'(1));

    for (genvar l = 0; l < N_SRC; l++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      mask_q[l] <= '0;
            else if (wr_en_i && (wr_lvl_i == IDX_W'(l)))     mask_q[l] <= wr_data_i;
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      stk_q[e] <= '0;
            else if (push_ok && (depth_q == DCW'(e)))        stk_q[e] <= mask_q[push_lvl_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       depth_q <= '0;
        else if (push_ok) depth_q <= depth_q + DCW'(1);
        else if (pop_ok)  depth_q <= depth_q - DCW'(1);
    end

    assign active_o = (depth_q == '0) ? '0 : stk_q[top_idx];

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DCW'(DEPTH)); // R10
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o) |=> depth_q == $past(depth_q) + DCW'(1)); // R8
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && depth_q == '0) |=> depth_q == '0); // R9
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int          N_SRC    = 4,
    parameter int          DEPTH    = 4,
    parameter int          VEC_W    = 8,
    parameter logic [7:0]  VEC_BASE = 8'h40,
    parameter int          IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             cpu_ie_i,
    input  logic             inta_i,
    input  logic             eos_i,
    input  logic             mask_we_i,
    input  logic [IDX_W-1:0] mask_lvl_i,
    input  logic [N_SRC-1:0] mask_data_i,
    output logic             intr_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             ie_clr_o
);
    ctl_state_t       state_q, state_d;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] active_mask;
    logic [N_SRC-1:0] elig;
    logic             stk_full;
    logic             any_elig;
    logic [IDX_W-1:0] win_idx;
    logic             grant;
    logic [VEC_W-1:0] vec_q;

    assign grant = (state_q == ST_RAISE) && inta_i;
    assign elig  = pend & ~active_mask & {N_SRC{!stk_full}};

    irq_req_latch #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .clr_vld_i (grant),
        .clr_idx_i (win_idx),
        .pend_o    (pend)
    );

    irq_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
        .elig_i (elig),
        .any_o  (any_elig),
        .idx_o  (win_idx)
    );

    irq_mask_stack #(.N_SRC(N_SRC), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (mask_we_i),
        .wr_lvl_i   (mask_lvl_i),
        .wr_data_i  (mask_data_i),
        .push_i     (grant),
        .push_lvl_i (win_idx),
        .pop_i      (eos_i),
        .active_o   (active_mask),
        .full_o     (stk_full)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (any_elig && cpu_ie_i)        state_d = ST_RAISE;
            ST_RAISE:  if (inta_i)                      state_d = ST_VECTOR;
                       else if (!(any_elig && cpu_ie_i)) state_d = ST_IDLE;
            ST_VECTOR:                                  state_d = ST_IDLE;
            default:                                    state_d = ST_IDLE;
        endcase
    end

    // Vector capture at the grant edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vec_q <= '0;
        else if (grant) vec_q <= VEC_W'(VEC_BASE) + (VEC_W'(win_idx) << 2);
    end

    // Outputs
    always_comb begin
        intr_o      = 1'b0;
        vec_valid_o = 1'b0;
        ie_clr_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RAISE:  intr_o = 1'b1;
            ST_VECTOR: begin
                vec_valid_o = 1'b1;
                ie_clr_o    = 1'b1;
            end
            default:   ;
        endcase
    end
    assign vec_o = vec_q;

    AST_IE_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_o && !cpu_ie_i && !inta_i) |=> !intr_o); // R4
    AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o); // R5
    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_o && inta_i) |=> vec_valid_o); // R5
    AST_IECLR_WITH_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ie_clr_o) |-> $past(intr_o && inta_i)); // R6
    AST_NO_GRANT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> !intr_o); // R10
endmodule

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb_top;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       ie = 1'b1;
    logic       inta = 1'b0;
    logic       eos = 1'b0;
    logic       mwe = 1'b0;
    logic [1:0] mlvl = '0;
    logic [3:0] mdat = '0;
    logic       intr, vvld, ieclr;
    logic [7:0] vec;

    int total = 0;
    int bad   = 0;
    logic [7:0] expq[$];
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    irq_nest_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cpu_ie_i(ie), .inta_i(inta),
        .eos_i(eos), .mask_we_i(mwe), .mask_lvl_i(mlvl), .mask_data_i(mdat),
        .intr_o(intr), .vec_valid_o(vvld), .vec_o(vec), .ie_clr_o(ieclr)
    );

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every vector strobe
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (vvld) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R5 unexpected vector", int'(vec), 0);
                end else begin
                    automatic logic [7:0] e = expq.pop_front();
                    chk(vec == e, "R3/R5 vector", int'(vec), int'(e));
                end
                chk(ieclr == 1'b1, "R6 ie clear with vector", int'(ieclr), 1);
            end else if (ieclr) begin
                chk(1'b0, "R6 ie clear without vector", 1, 0);
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_mask(input logic [1:0] l, input logic [3:0] d);
        mwe = 1'b1; mlvl = l; mdat = d;
        cyc(1);
        mwe = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m);
        req = req | m;
        cyc(1);
        req = req & ~m;
    endtask

    task automatic ack(input logic [7:0] e);
        chk(intr == 1'b1, "R4 intr before ack", int'(intr), 1);
        expq.push_back(e);
        inta = 1'b1;
        cyc(1);
        inta = 1'b0;
    endtask

    task automatic end_srv();
        eos = 1'b1;
        cyc(1);
        eos = 1'b0;
    endtask

    task automatic expect_intr(input logic v, input string tag);
        chk(intr == v, tag, int'(intr), int'(v));
    endtask

    initial begin
        cyc(2);
        // R1 reset state
        expect_intr(1'b0, "R1 intr at reset");
        chk(vvld == 1'b0 && ieclr == 1'b0, "R1 vector idle at reset", int'({vvld, ieclr}), 0);
        rst_n = 1'b1;
        cyc(3);
        expect_intr(1'b0, "R1 nothing pending after reset");

        // R7 program masks: shorter service time ranks higher
        wr_mask(2'd0, 4'b1011);
        wr_mask(2'd1, 4'b0010);
        wr_mask(2'd2, 4'b1111);
        wr_mask(2'd3, 4'b1010);

        // B and D together: fixed order picks B, D then nests under B
        pulse(4'b1010); cyc(2);
        expect_intr(1'b1, "R2 edge latched");
        ack(8'h44); cyc(2);
        expect_intr(1'b1, "R8 D preempts B");
        ack(8'h4C);
        pulse(4'b0010); cyc(3);
        expect_intr(1'b0, "R7 B blocked by D mask");
        end_srv(); cyc(3);
        expect_intr(1'b0, "R9 B mask restored blocks B");
        end_srv(); cyc(2);
        expect_intr(1'b1, "R11 B served once unmasked");
        ack(8'h44); end_srv(); cyc(3);
        expect_intr(1'b0, "R8 empty stack idle");

        // Enable gating
        ie = 1'b0;
        pulse(4'b0001); cyc(3);
        expect_intr(1'b0, "R4 no intr while disabled");
        ie = 1'b1; cyc(2);
        expect_intr(1'b1, "R4 intr after enable");
        ie = 1'b0; cyc(1);
        expect_intr(1'b0, "R4 intr withdrawn");
        ie = 1'b1; cyc(2);
        ack(8'h40);

        // All four at once while A is in service
        pulse(4'b1111); cyc(2);
        expect_intr(1'b1, "R7 C unmasked under A");
        ack(8'h48); cyc(3);
        expect_intr(1'b0, "R7 C masks all");
        end_srv(); cyc(3);
        expect_intr(1'b0, "R9 A mask restored");
        end_srv(); cyc(2);
        ack(8'h40);
        end_srv(); cyc(2);
        ack(8'h44); cyc(2);
        ack(8'h4C);
        end_srv(); end_srv(); cyc(3);
        expect_intr(1'b0, "R3 all drained");

        // Held request line
        req[0] = 1'b1; cyc(2);
        ack(8'h40); end_srv(); cyc(4);
        expect_intr(1'b0, "R2 held line not relatched");
        req[0] = 1'b0; cyc(1);

        // Mask copied at grant time
        wr_mask(2'd0, 4'b0000);
        pulse(4'b0001); cyc(2);
        ack(8'h40);
        wr_mask(2'd0, 4'b1111);
        pulse(4'b0010); cyc(2);
        expect_intr(1'b1, "R7 pushed mask unchanged by write");
        ack(8'h44); end_srv(); end_srv();

        // Stack full
        for (int l = 0; l < 4; l++) wr_mask(2'(l), 4'b0000);
        for (int k = 0; k < 4; k++) begin
            pulse(4'b0001); cyc(2);
            ack(8'h40);
        end
        pulse(4'b0001); cyc(4);
        expect_intr(1'b0, "R10 full stack blocks");
        end_srv(); cyc(2);
        expect_intr(1'b1, "R10 freed entry unblocks");
        ack(8'h40);
        for (int k = 0; k < 4; k++) end_srv();

        // End-of-service with empty stack
        end_srv(); end_srv();
        wr_mask(2'd0, 4'b1111);
        pulse(4'b0001); cyc(2);
        ack(8'h40);
        pulse(4'b0010); cyc(3);
        expect_intr(1'b0, "R9 level still active after empty pops");
        end_srv(); cyc(2);
        expect_intr(1'b1, "R9 single pop empties stack");
        ack(8'h44); end_srv(); cyc(3);

        chk(expq.size() == 0, "R5 all vectors seen", expq.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R1 watchdog actual=%0h expected=%0h", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule